// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block sits on the device side of a flash array. It decides what a read returns while an internal program or erase operation is running. A start pulse launches the operation. The pulse records whether the operation is a program or an erase, the most significant bit of the byte being programmed, and a busy duration in clock cycles that a down-counter then runs off.

While the operation is busy, or after it has failed, every read returns a status word instead of array data:

- The top data bit is the polling bit. Its meaning depends on the operation type.
- The next bit is a toggle bit. It inverts on every read access, not on every clock.
- All lower bits read as zero.

When the counter runs out, the block returns to plain array reads by itself. A fail input from the operation engine freezes the block in the fail state, where status keeps being returned. Only a clear-fail pulse releases it.

Reads are synchronous. A read strobe high at a rising edge loads the read data register on that edge. Array data is sampled on that same edge.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the read data register is zero, the block is in read mode (a read returns `arrayData`), and the toggle flip-flop is 0, so the first status read shows bit DW-2 equal to 0.
- R2: During a program operation, a status read returns bit DW-1 equal to the inverse of bit DW-1 of the write data captured at start, and bits DW-3..0 equal to zero.
- R3: During an erase operation, a status read returns bit DW-1 equal to 0 and bits DW-3..0 equal to zero.
- R4: Bit DW-2 of a status read equals the toggle flip-flop, which inverts once per status read. Clock cycles without a read leave it unchanged.
- R5: An operation accepted at edge E0 with count N returns status for reads at edges E1 through E(N+1). From edge E(N+2) on, reads return `arrayData` without any further input.
- R6: A `failIn` pulse during a busy operation puts the block in a fail state. In that state reads keep returning status: bit DW-1 keeps its busy value and bit DW-2 keeps toggling. This continues until a `clearFail` pulse, after which reads return `arrayData`.
- R7: Start pulses that arrive while an operation is busy or failed are ignored. The type, the captured data bit and the counter are unchanged.
- R8: The read data register holds its value on every edge where `rdEn` is low.
- R9: If `startProg` and `startErase` are high together while idle, the operation is an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe, one read per edge where it is high |
| arrayData | input | DW | Array cell data for the current read address |
| rdData | output | DW | Registered read data |
| startProg | input | 1 | Start a program operation (idle only) |
| startErase | input | 1 | Start an erase operation (idle only) |
| wrData | input | DW | Byte being programmed, captured at start |
| opCycles | input | CW | Busy duration count, loaded at start |
| failIn | input | 1 | Operation engine reports failure |
| clearFail | input | 1 | Return from the fail state to read mode |

## Verification
The bench builds the block with DW = 8 and CW = 4. The 4-bit count allows durations from a single busy cycle (count 0) up to sixteen cycles, so both ends of the busy window stay within a few reads. The last status edge and the first array edge are probed directly. The bench runs program operations with both values of the top data bit and an erase with a zero count. It runs a fail with release, start pulses during busy and fail, and a simultaneous program and erase start. Idle gaps between reads show that the toggle bit advances per access and not per clock.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FAIL = 2'd2
  } opState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureOp;   // accept a new operation this edge
    logic opIsErase;   // type of the accepted operation
    logic statusSel;   // reads return status instead of array data
    logic readHit;     // a read happens this edge
  } dpCtrl_t;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import flash_stat_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic          startProg,
  input  logic          startErase,
  input  logic [CW-1:0] opCycles,
  input  logic          failIn,
  input  logic          clearFail,
  output dpCtrl_t       ctrl,
  output opState_t      curState
);

  opState_t      stateQ, stateD;
  logic [CW-1:0] cntQ, cntD;
  logic          accept;

  assign accept = (stateQ == ST_IDLE) && (startProg || startErase);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          stateD = ST_BUSY;
          cntD   = opCycles;
        end
      end
      ST_BUSY: begin
        if (failIn) begin
          stateD = ST_FAIL;
        end else if (cntQ == '0) begin
          stateD = ST_IDLE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_FAIL: begin
        if (clearFail) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    ctrl.captureOp = accept;
    ctrl.opIsErase = startErase;
    ctrl.statusSel = (stateQ != ST_IDLE);
    ctrl.readHit   = rdEn;
  end

  assign curState = stateQ;

endmodule

// File: rtl/fsr_dpath.sv
module fsr_dpath
  import flash_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctrl,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  output logic          toggleQ,
  output logic          eraseQ
);

  localparam int MSB = DW - 1;
  localparam int TGB = DW - 2;

  logic          progMsbQ;
  logic          pollBit;
  logic [DW-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseQ   <= 1'b0;
      progMsbQ <= 1'b0;
    end else if (ctrl.captureOp) begin
      eraseQ   <= ctrl.opIsErase;
      progMsbQ <= wrData[MSB];
    end
  end

  assign pollBit = eraseQ ? 1'b0 : ~progMsbQ;

  always_comb begin
    statusWord      = '0;
    statusWord[MSB] = pollBit;
    statusWord[TGB] = toggleQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else if (ctrl.readHit) begin
      if (ctrl.statusSel) begin
        rdData  <= statusWord;
        toggleQ <= ~toggleQ;
      end else begin
        rdData <= arrayData;
      end
    end
  end

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_stat_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  input  logic          startProg,
  input  logic          startErase,
  input  logic [DW-1:0] wrData,
  input  logic [CW-1:0] opCycles,
  input  logic          failIn,
  input  logic          clearFail
);

  dpCtrl_t  ctrlBus;
  opState_t curState;
  logic     togBit;
  logic     eraseOp;

  fsr_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdEn       (rdEn),
    .startProg  (startProg),
    .startErase (startErase),
    .opCycles   (opCycles),
    .failIn     (failIn),
    .clearFail  (clearFail),
    .ctrl       (ctrlBus),
    .curState   (curState)
  );

  fsr_dpath #(.DW(DW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .wrData    (wrData),
    .arrayData (arrayData),
    .rdData    (rdData),
    .toggleQ   (togBit),
    .eraseQ    (eraseOp)
  );

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
  import flash_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdEn,
  input logic [DW-1:0] arrayData,
  input logic [DW-1:0] rdData,
  input logic          clearFail,
  input opState_t      curState,
  input logic          togBit,
  input logic          eraseOp
);

  logic inStatus;
  assign inStatus = (curState != ST_IDLE);

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inStatus) |=> (rdData[DW-3:0] == '0));

  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inStatus && eraseOp) |=> (rdData[DW-1] == 1'b0));

  // R4
  toggle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inStatus) |=> (rdData[DW-2] == $past(togBit)));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |=> $stable(togBit));

  // R5
  array_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !inStatus) |=> (rdData == $past(arrayData)));

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_FAIL && !clearFail) |=> (curState == ST_FAIL));

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |=> $stable(rdData));

endmodule

bind flash_status_resp fsr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .arrayData (arrayData),
  .rdData    (rdData),
  .clearFail (clearFail),
  .curState  (curState),
  .togBit    (togBit),
  .eraseOp   (eraseOp)
);

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;

  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          rdEn;
  logic [DW-1:0] arrayData;
  logic [DW-1:0] rdData;
  logic          startProg;
  logic          startErase;
  logic [DW-1:0] wrData;
  logic [CW-1:0] opCycles;
  logic          failIn;
  logic          clearFail;

  int nChecks = 0;
  int nFails  = 0;
  logic expTog = 1'b0;

  always #5 clk = ~clk;

  flash_status_resp #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .arrayData(arrayData),
    .rdData(rdData), .startProg(startProg), .startErase(startErase),
    .wrData(wrData), .opCycles(opCycles), .failIn(failIn),
    .clearFail(clearFail)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one read edge; data sampled at the following negedge
  task automatic doRead(output logic [DW-1:0] val);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  function automatic logic [DW-1:0] statusOf(input logic poll);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1] = poll;
    w[DW-2] = expTog;
    expTog = ~expTog;
    return w;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startOp(input logic prog, input logic erase,
                         input logic [DW-1:0] d, input logic [CW-1:0] n);
    startProg = prog; startErase = erase; wrData = d; opCycles = n;
    @(negedge clk);
    startProg = 1'b0; startErase = 1'b0;
  endtask

  task automatic tReset();
    logic [DW-1:0] v;
    check("R1 reset rdData", rdData, '0);
    arrayData = 8'h5A;
    doRead(v);
    check("R1 read mode after reset", v, 8'h5A);
  endtask

  task automatic tProgram();
    logic [DW-1:0] v, held;
    arrayData = 8'hA5;
    startOp(1'b1, 1'b0, 8'hA5, 4'd10);             // E0
    doRead(v); check("R2 program status msb1", v, statusOf(1'b0)); // E1
    doRead(v); check("R4 toggle second read", v, statusOf(1'b0));  // E2
    doRead(v); check("R4 toggle third read", v, statusOf(1'b0));   // E3
    held = v;
    idle(3);                                       // E4..E6
    check("R8 hold without read", rdData, held);
    doRead(v); check("R4 no flip on idle clocks", v, statusOf(1'b0)); // E7
    idle(3);                                       // E8..E10
    doRead(v); check("R5 last busy edge", v, statusOf(1'b0));      // E11
    doRead(v); check("R5 auto return to array", v, 8'hA5);         // E12
  endtask

  task automatic tEraseZero();
    logic [DW-1:0] v;
    arrayData = 8'hFF;
    startOp(1'b0, 1'b1, 8'h00, 4'd0);
    doRead(v); check("R3 erase status count0", v, statusOf(1'b0));
    doRead(v); check("R5 erase done array", v, 8'hFF);
  endtask

  task automatic tProgLowIgnore();
    logic [DW-1:0] v;
    arrayData = 8'h12;
    startOp(1'b1, 1'b0, 8'h12, 4'd5);              // E0
    doRead(v); check("R2 program status msb0", v, statusOf(1'b1)); // E1
    startOp(1'b0, 1'b1, 8'hFF, 4'd15);             // E2 ignored
    doRead(v); check("R7 start ignored when busy", v, statusOf(1'b1)); // E3
    idle(2);                                       // E4,E5
    doRead(v); check("R7 count not reloaded", v, statusOf(1'b1));  // E6
    doRead(v); check("R7 done at original count", v, 8'h12);       // E7
  endtask

  task automatic tFail();
    logic [DW-1:0] v;
    arrayData = 8'h80;
    startOp(1'b1, 1'b0, 8'h80, 4'd3);              // E0
    failIn = 1'b1; @(negedge clk); failIn = 1'b0;  // E1
    idle(10);
    doRead(v); check("R6 fail keeps poll", v, statusOf(1'b0));
    doRead(v); check("R6 fail keeps toggling", v, statusOf(1'b0));
    startOp(1'b0, 1'b1, 8'h00, 4'd0);
    doRead(v); check("R7 start ignored in fail", v, statusOf(1'b0));
    clearFail = 1'b1; @(negedge clk); clearFail = 1'b0;
    doRead(v); check("R6 clear returns array", v, 8'h80);
  endtask

  task automatic tBothStart();
    logic [DW-1:0] v;
    arrayData = 8'h3C;
    startOp(1'b1, 1'b1, 8'h00, 4'd1);              // program would give msb 1
    doRead(v); check("R9 erase wins", v, statusOf(1'b0));
    doRead(v); check("R9 still busy", v, statusOf(1'b0));
    doRead(v); check("R9 done", v, 8'h3C);
  endtask

  initial begin
    rstN = 1'b0; rdEn = 1'b0; arrayData = '0; startProg = 1'b0;
    startErase = 1'b0; wrData = '0; opCycles = '0; failIn = 1'b0;
    clearFail = 1'b0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tProgram();
    tEraseZero();
    tProgLowIgnore();
    tFail();
    tBothStart();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule